// File: doc/BRIEF.md
# Programmable-Length Serial Receive Deserializer

This block assembles a serial bit stream into a parallel word. An upstream recovery stage supplies a data bit together with a one-cycle bit strobe. Software arms each frame by writing a bit count. When that many bits have been shifted in, the assembled word moves to a receive buffer. Software then reads the buffer through a small register port.

An end-of-packet pulse from an upstream line-state detector can end a frame before the count is reached. The partial word is still delivered, right-justified. The count register is overwritten with the number of bits that actually arrived, and an end-of-packet status flag is raised. A buffer-full flag, an overrun flag and a per-flag interrupt enable complete the software view. A polarity control inverts the incoming data.

Top module: `serial_rx_deser`

## Requirements
- R1: A write to register address 0 arms a new frame: reception starts from an empty word, and reading address 0 returns the written value in bits [4:0].
- R2: Each strobed bit is stored LSB first, so buffer bit i (address 1) holds the i-th bit received in the frame.
- R3: When the programmed number of bits has arrived, the word is loaded into the buffer and status bit 0 (full) is set. Bits and end-of-packet pulses that arrive after that, until the next arm, have no effect.
- R4: A programmed count of 0 receives 16 bits.
- R5: An end-of-packet pulse before the count is reached loads the partial word into the buffer (bit 0 = first bit) and sets status bit 1 (eop). It also sets status bit 0 and replaces the count register with the number of bits received.
- R6: A read strobe at address 1 clears status bit 0.
- R7: A buffer load while status bit 0 is set, with no buffer read in the same cycle, sets status bit 2 (overrun).
- R8: Writing 1 to a status bit at address 2 clears that bit. Bits written as 0 are unchanged.
- R9: The irq output is high exactly when some status bit is set and its enable is set. The enables are control register (address 3) bits [2:0], which line up with status bits [2:0].
- R10: Control bit 3 inverts every received data bit before it is stored.
- R11: After reset, all registers read 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bit_en | input | 1 | Strobe: one received bit is valid this cycle |
| rx_bit | input | 1 | Received data bit |
| eop_in | input | 1 | End-of-packet pulse from upstream detector |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 2 | Register address: 0 count, 1 buffer, 2 status, 3 control |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Receive interrupt |

## Verification
The bench builds the block with its default parameters: a 16-bit maximum frame and a 16-bit register port. With these values, programmed counts from 0 through 16 are within reach, including the 0-means-full-width case. End-of-packet cut points can fall at any bit position, including before the first bit. Random frames mix polarity, interrupt enables and early terminations. Directed sequences cover overrun, partial write-one-to-clear, and stimulus that arrives after a frame has completed.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [1:0] {
    RA_COUNT = 2'd0,
    RA_DATA  = 2'd1,
    RA_STAT  = 2'd2,
    RA_CTRL  = 2'd3
  } rxd_addr_e;

  // status bit positions
  localparam int unsigned ST_FULL = 0;
  localparam int unsigned ST_EOP  = 1;
  localparam int unsigned ST_OVR  = 2;
  localparam int unsigned CTRL_INV = 3;

  // programmed count to effective frame length
  function automatic int unsigned eff_len(input int unsigned cnt, input int unsigned max_bits);
    if (cnt == 0 || cnt > max_bits) return max_bits;
    return cnt;
  endfunction
endpackage

// File: rtl/rxd_shift_core.sv
module rxd_shift_core #(
  parameter int unsigned MAX_BITS = 16,
  parameter int unsigned CW = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm,
  input  logic [CW-1:0]       arm_len,
  input  logic                bit_en,
  input  logic                bit_in,
  input  logic                eop_in,
  output logic                active,
  output logic                load_evt,
  output logic                eop_evt,
  output logic [MAX_BITS-1:0] word,
  output logic [CW-1:0]       got_cnt,
  output logic [CW-1:0]       target
);
  logic [CW-1:0]       target_q, got_q, got_n;
  logic [MAX_BITS-1:0] sh_q, sh_n, bit_mask;
  logic                act_q, take, full_hit, early;

  assign take     = act_q & bit_en & ~arm;
  assign got_n    = got_q + CW'(take);
  assign bit_mask = MAX_BITS'(1) << got_q;
  assign sh_n     = (take & bit_in) ? (sh_q | bit_mask) : sh_q;
  assign full_hit = take && (got_n == target_q);
  assign early    = act_q & ~arm & eop_in & ~full_hit;

  assign load_evt = full_hit | early;
  assign eop_evt  = early;
  assign word     = sh_n;
  assign got_cnt  = got_n;
  assign active   = act_q;
  assign target   = target_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      got_q    <= '0;
      sh_q     <= '0;
      act_q    <= 1'b0;
    end else if (arm) begin
      target_q <= CW'(rxd_pkg::eff_len(32'(arm_len), MAX_BITS));
      got_q    <= '0;
      sh_q     <= '0;
      act_q    <= 1'b1;
    end else if (act_q) begin
      got_q <= got_n;
      sh_q  <= sh_n;
      if (load_evt) act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rxd_regfile.sv
module rxd_regfile #(
  parameter int unsigned MAX_BITS = 16,
  parameter int unsigned CW = $clog2(MAX_BITS + 1),
  parameter int unsigned REG_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [1:0]          reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic                irq,
  input  logic                load_evt,
  input  logic                eop_evt,
  input  logic [MAX_BITS-1:0] word,
  input  logic [CW-1:0]       got_cnt,
  output logic                arm,
  output logic [CW-1:0]       arm_len,
  output logic                invert,
  output logic                buf_rd,
  output logic [2:0]          flags,
  output logic [2:0]          ie,
  output logic [CW-1:0]       count_q
);
  import rxd_pkg::*;

  logic [MAX_BITS-1:0] buf_q;
  logic [3:0]          ctrl_q;
  logic [2:0]          flag_q, w1c;
  logic                ovr_set;

  assign arm     = reg_wr && (reg_addr == RA_COUNT);
  assign arm_len = reg_wdata[CW-1:0];
  assign buf_rd  = reg_rd && (reg_addr == RA_DATA);
  assign w1c     = (reg_wr && reg_addr == RA_STAT) ? reg_wdata[2:0] : 3'b000;
  assign ovr_set = load_evt & flag_q[ST_FULL] & ~buf_rd;
  assign invert  = ctrl_q[CTRL_INV];
  assign ie      = ctrl_q[2:0];
  assign flags   = flag_q;
  assign irq     = |(flag_q & ctrl_q[2:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      buf_q   <= '0;
      ctrl_q  <= '0;
      flag_q  <= '0;
    end else begin
      if (arm) count_q <= arm_len;
      else if (eop_evt) count_q <= got_cnt;
      if (load_evt) buf_q <= word;
      if (reg_wr && reg_addr == RA_CTRL) ctrl_q <= reg_wdata[3:0];
      flag_q[ST_FULL] <= load_evt | (flag_q[ST_FULL] & ~buf_rd & ~w1c[ST_FULL]);
      flag_q[ST_EOP]  <= eop_evt  | (flag_q[ST_EOP]  & ~w1c[ST_EOP]);
      flag_q[ST_OVR]  <= ovr_set  | (flag_q[ST_OVR]  & ~w1c[ST_OVR]);
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_COUNT: reg_rdata[CW-1:0]       = count_q;
      RA_DATA:  reg_rdata[MAX_BITS-1:0] = buf_q;
      RA_STAT:  reg_rdata[2:0]          = flag_q;
      default:  reg_rdata[3:0]          = ctrl_q;
    endcase
  end
endmodule

// File: rtl/serial_rx_deser.sv
module serial_rx_deser #(
  parameter int unsigned MAX_BITS = 16,
  parameter int unsigned REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit_en,
  input  logic             rx_bit,
  input  logic             eop_in,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq
);
  localparam int unsigned CW = $clog2(MAX_BITS + 1);

  // named internal events for the checker
  logic                arm, invert, active, load_evt, eop_evt, buf_rd;
  logic [CW-1:0]       arm_len, got_cnt, target, count_q;
  logic [MAX_BITS-1:0] word;
  logic [2:0]          flags, ie;

  rxd_shift_core #(.MAX_BITS(MAX_BITS), .CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .arm(arm), .arm_len(arm_len),
    .bit_en(rx_bit_en), .bit_in(rx_bit ^ invert), .eop_in(eop_in),
    .active(active), .load_evt(load_evt), .eop_evt(eop_evt),
    .word(word), .got_cnt(got_cnt), .target(target)
  );

  rxd_regfile #(.MAX_BITS(MAX_BITS), .CW(CW), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .load_evt(load_evt), .eop_evt(eop_evt), .word(word),
    .got_cnt(got_cnt), .arm(arm), .arm_len(arm_len), .invert(invert),
    .buf_rd(buf_rd), .flags(flags), .ie(ie), .count_q(count_q)
  );
endmodule

// File: rtl/rxd_checker.sv
module rxd_checker #(
  parameter int unsigned CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic [CW-1:0] arm_len,
  input logic          active,
  input logic          load_evt,
  input logic          eop_evt,
  input logic          buf_rd,
  input logic [CW-1:0] got_cnt,
  input logic [CW-1:0] target,
  input logic [CW-1:0] count_q,
  input logic [2:0]    flags,
  input logic [2:0]    ie,
  input logic          irq
);
  assert_arm_R1: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (active && count_q == $past(arm_len)));

  assert_load_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (flags[0] && !active));

  assert_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !eop_evt) |-> (got_cnt == target));

  assert_eop_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eop_evt |=> (flags[1] && count_q == $past(got_cnt)));

  assert_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && flags[0] && !buf_rd) |=> flags[2]);

  assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flags[0]) && ie[0]) |-> irq);
endmodule

bind serial_rx_deser rxd_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .arm_len(arm_len), .active(active),
  .load_evt(load_evt), .eop_evt(eop_evt), .buf_rd(buf_rd),
  .got_cnt(got_cnt), .target(target), .count_q(count_q),
  .flags(flags), .ie(ie), .irq(irq)
);

// File: tb/sim_serial_rx_deser.sv
`timescale 1ns/1ps
module sim_serial_rx_deser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_bit_en = 1'b0, rx_bit = 1'b0, eop_in = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  serial_rx_deser u0 (
    .clk(clk), .rst_n(rst_n), .rx_bit_en(rx_bit_en), .rx_bit(rx_bit),
    .eop_in(eop_in), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic int unsigned frame_len(input int unsigned c);
    return (c == 0) ? 16 : c;
  endfunction

  function automatic logic [15:0] pack(input logic [15:0] bits, input int unsigned n, input bit inv);
    logic [15:0] w = '0;
    for (int i = 0; i < n; i++) w[i] = bits[i] ^ inv;
    return w;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input bit strobe, output logic [15:0] d);
    reg_addr = a; reg_rd = strobe;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    rx_bit_en = 1'b1; rx_bit = b;
    @(negedge clk);
    rx_bit_en = 1'b0;
  endtask

  task automatic pulse_eop();
    eop_in = 1'b1;
    @(negedge clk);
    eop_in = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, bits, exp_w;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], 1'b0, d); check("R11 reset reg", d, 16'h0);
    end
    check("R11 reset irq", {15'b0, irq}, 16'h0);

    // R1 R4 directed: count 0 gives 16 bits
    wr(2'd0, 16'd0);
    rd(2'd0, 1'b0, d); check("R1 count readback", d, 16'd0);
    bits = 16'hA5C3;
    for (int i = 0; i < 15; i++) send_bit(bits[i]);
    rd(2'd2, 1'b0, d); check("R4 not full after 15", d, 16'h0);
    send_bit(bits[15]);
    rd(2'd1, 1'b0, d); check("R4 16-bit word", d, bits);
    rd(2'd2, 1'b0, d); check("R3 full set", d, 16'h1);

    // R7 overrun, R8 partial W1C, R6 read clears
    wr(2'd0, 16'd2); send_bit(1'b1); send_bit(1'b0);
    rd(2'd2, 1'b0, d); check("R7 overrun set", d, 16'h5);
    rd(2'd1, 1'b0, d); check("R7 newest word kept", d, 16'h1);
    wr(2'd2, 16'h4);
    rd(2'd2, 1'b0, d); check("R8 only bit2 cleared", d, 16'h1);
    rd(2'd1, 1'b1, d);
    rd(2'd2, 1'b0, d); check("R6 read clears full", d, 16'h0);

    // R5 EOP before any bit
    wr(2'd0, 16'd9); pulse_eop();
    rd(2'd0, 1'b0, d); check("R5 zero bits count", d, 16'h0);
    rd(2'd2, 1'b0, d); check("R5 eop+full", d, 16'h3);
    rd(2'd1, 1'b1, d); wr(2'd2, 16'h7);

    // random frames
    for (int f = 0; f < 60; f++) begin
      int unsigned cnt, len, stop;
      bit inv, early;
      logic [2:0] ien, exp_st;
      inv   = $urandom_range(0, 1);
      ien   = 3'($urandom_range(0, 7));
      cnt   = $urandom_range(0, 16);
      len   = frame_len(cnt);
      early = ($urandom_range(0, 2) == 0);
      stop  = early ? $urandom_range(0, len - 1) : len;
      bits  = 16'($urandom);
      wr(2'd3, {12'h0, inv, ien});
      wr(2'd0, 16'(cnt));
      for (int i = 0; i < stop; i++) send_bit(bits[i]);
      if (early) pulse_eop();
      else begin
        send_bit(~bits[0]); pulse_eop();   // R3: after completion, ignored
      end
      exp_w  = pack(bits, stop, inv);
      exp_st = {1'b0, early, 1'b1};
      rd(2'd1, 1'b0, d); check(early ? "R5 partial word R2 R10" : "R2 word R10 R3", d, exp_w);
      rd(2'd0, 1'b0, d); check(early ? "R5 count rewrite" : "R1 count kept", d, early ? 16'(stop) : 16'(cnt));
      rd(2'd2, 1'b0, d); check("R3 R5 status", d, {13'h0, exp_st});
      check("R9 irq", {15'b0, irq}, {15'b0, |(exp_st & ien)});
      rd(2'd1, 1'b1, d);
      rd(2'd2, 1'b0, d); check("R6 full cleared", d, {13'h0, exp_st & 3'b110});
      wr(2'd2, 16'h7);
      rd(2'd2, 1'b0, d); check("R8 all cleared", d, 16'h0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule